// File: doc/BRIEF.md
# Two-Speed Processor Clock Generator

This block builds a processor clock from a single fast reference clock and offers two speeds. In normal mode each half-period of the output lasts five reference cycles. The reference is 20.480 MHz, so the processor clock is 2.048 MHz. In turbo mode each half-period lasts two reference cycles, which gives 5.120 MHz. Both speeds are counted from the same reference, so the output stays phase-locked to it at either speed.

The speed-select input may change at any time and with no relation to the reference. It first passes through a flop synchronizer. The new rate is then taken up only on the reference edge where the output toggles. Every high and low phase therefore belongs wholly to one rate, and no switch can produce a runt pulse that would upset the processor. The `turbo_active` output shows the rate that governs the current phase.

Top module: `two_speed_clkgen`

## Requirements
- R1: While `rst_n` is low, `cpu_clk` is 0 and `turbo_active` is 0 (normal rate).
- R2: While the normal rate is in effect, every high and low phase of `cpu_clk` lasts NORMAL_DIV (5) reference cycles. The first phase after reset is low and has this length.
- R3: While the turbo rate is in effect, every high and low phase of `cpu_clk` lasts TURBO_DIV (2) reference cycles.
- R4: `turbo_active` changes only on a reference edge where `cpu_clk` also toggles.
- R5: Whatever the select does, no phase of `cpu_clk` is shorter than TURBO_DIV or longer than NORMAL_DIV reference cycles.
- R6: The length of each phase is set by the value `turbo_active` holds during that phase (1 selects TURBO_DIV, 0 selects NORMAL_DIV).
- R7: `speed_sel` (1 requests turbo) passes through a two-flop synchronizer. The rate taken up at a toggling edge is the value `speed_sel` had at the reference edge two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_sel | input | 1 | Asynchronous speed request, 1 = turbo |
| cpu_clk | output | 1 | Generated processor clock |
| turbo_active | output | 1 | Rate governing the current phase, 1 = turbo |

## Verification
The assertions assume that the divide parameters satisfy 1 <= TURBO_DIV < NORMAL_DIV and that `speed_sel` is a level, so only its value at reference edges matters. They make no assumption about when the select changes. The stimulus moves `speed_sel` away from the active edge. It mixes long steady holds at each speed with flips on every cycle, flips every few cycles and random flips from a seeded generator. This exercises requests that land mid-phase, requests just before a toggle and requests withdrawn before they take effect.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   typedef enum logic {
      RATE_NORMAL = 1'b0,
      RATE_TURBO  = 1'b1
   } rate_e;

   function automatic int unsigned cnt_width(input int unsigned max_count);
      return (max_count <= 2) ? 1 : $clog2(max_count);
   endfunction
endpackage

// File: rtl/ckd_sync.sv
module ckd_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RESET_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ckd_phase_counter.sv
module ckd_phase_counter
   import clkdiv_pkg::*;
#(
   parameter int unsigned NORMAL_DIV = 5,
   parameter int unsigned TURBO_DIV  = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rate_e rate_req,
   output logic  phase_end,
   output rate_e rate_now
);
   localparam int unsigned CNT_W      = cnt_width(NORMAL_DIV);
   localparam logic [CNT_W-1:0] LAST_NORMAL = CNT_W'(NORMAL_DIV - 1);
   localparam logic [CNT_W-1:0] LAST_TURBO  = CNT_W'(TURBO_DIV - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;

   always_comb begin
      last_cnt  = (rate_now == RATE_TURBO) ? LAST_TURBO : LAST_NORMAL;
      phase_end = (cnt == last_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         rate_now <= RATE_NORMAL;
      end else if (phase_end) begin
         cnt      <= '0;
         rate_now <= rate_req;
      end else begin
         cnt      <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ckd_toggle.sv
module ckd_toggle #(
   parameter bit START_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic level
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    level <= START_LEVEL;
      else if (flip) level <= ~level;
   end
endmodule

// File: rtl/two_speed_clkgen.sv
module two_speed_clkgen
   import clkdiv_pkg::*;
#(
   parameter int unsigned NORMAL_DIV  = 5,
   parameter int unsigned TURBO_DIV   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          START_LEVEL = 1'b0
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic speed_sel,
   output logic cpu_clk,
   output logic turbo_active
);
   generate
      if (TURBO_DIV < 1) begin : g_bad_turbo
         $error("TURBO_DIV must be at least 1");
      end
      if (NORMAL_DIV <= TURBO_DIV) begin : g_bad_order
         $error("NORMAL_DIV must exceed TURBO_DIV");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic  sel_sync;
   rate_e rate_req;
   rate_e rate_now;
   logic  phase_end;

   ckd_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b0)
   ) u_sync (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .d_async (speed_sel),
      .q_sync  (sel_sync)
   );

   assign rate_req = sel_sync ? RATE_TURBO : RATE_NORMAL;

   ckd_phase_counter #(
      .NORMAL_DIV (NORMAL_DIV),
      .TURBO_DIV  (TURBO_DIV)
   ) u_count (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .rate_req  (rate_req),
      .phase_end (phase_end),
      .rate_now  (rate_now)
   );

   ckd_toggle #(
      .START_LEVEL (START_LEVEL)
   ) u_out (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .flip  (phase_end),
      .level (cpu_clk)
   );

   assign turbo_active = (rate_now == RATE_TURBO);
endmodule

// File: rtl/ckd_checker.sv
module ckd_checker #(
   parameter int unsigned NORMAL_DIV  = 5,
   parameter int unsigned TURBO_DIV   = 2,
   parameter bit          START_LEVEL = 1'b0
) (
   input logic clk_ref,
   input logic rst_n,
   input logic cpu_clk,
   input logic turbo_active
);
   localparam int unsigned RUN_W = $clog2(NORMAL_DIV + 2) + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

   logic             prev_clk;
   logic             prev_turbo;
   logic [RUN_W-1:0] run;
   logic             seen_edge;

   assign seen_edge = (cpu_clk != prev_clk);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         prev_clk   <= START_LEVEL;
         prev_turbo <= 1'b0;
         run        <= '0;
      end else begin
         prev_clk   <= cpu_clk;
         prev_turbo <= turbo_active;
         if (seen_edge)          run <= RUN_W'(1);
         else if (run != RUN_MAX) run <= run + 1'b1;
      end
   end

   always_ff @(posedge clk_ref) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert ((cpu_clk == START_LEVEL) && !turbo_active); // R1
      end
   end

   AST_RATE_AT_TOGGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (turbo_active != prev_turbo) |-> seen_edge); // R4

   AST_PHASE_FLOOR: assert property (@(posedge clk_ref) disable iff (!rst_n)
      seen_edge |-> (run >= RUN_W'(TURBO_DIV))); // R5

   AST_PHASE_CEIL: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !seen_edge |-> (run <= RUN_W'(NORMAL_DIV))); // R5

   AST_PHASE_MATCHES_RATE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      seen_edge |-> (run == (prev_turbo ? RUN_W'(TURBO_DIV) : RUN_W'(NORMAL_DIV)))); // R6
endmodule

bind two_speed_clkgen ckd_checker #(
   .NORMAL_DIV  (NORMAL_DIV),
   .TURBO_DIV   (TURBO_DIV),
   .START_LEVEL (START_LEVEL)
) u_chk (
   .clk_ref      (clk_ref),
   .rst_n        (rst_n),
   .cpu_clk      (cpu_clk),
   .turbo_active (turbo_active)
);

// File: tb/two_speed_clkgen_tb.sv
module two_speed_clkgen_tb;
   localparam int ND = 5;
   localparam int TD = 2;

   logic clk_ref = 1'b0;
   logic rst_n   = 1'b0;
   logic speed_sel = 1'b0;
   logic cpu_clk;
   logic turbo_active;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk_ref = ~clk_ref;

   two_speed_clkgen #(.NORMAL_DIV(ND), .TURBO_DIV(TD)) u_dut (
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .speed_sel    (speed_sel),
      .cpu_clk      (cpu_clk),
      .turbo_active (turbo_active)
   );

   function automatic int exp_phase(input logic turbo);
      return turbo ? TD : ND;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   logic       prev_clk, prev_tb;
   logic [2:0] hist;
   int         run;

   task automatic step(input logic next_sel);
      @(negedge clk_ref);
      hist = {hist[1:0], speed_sel};
      if (cpu_clk != prev_clk) begin
         if (prev_tb) chk(run == exp_phase(1'b1), "R3", run, exp_phase(1'b1));
         else         chk(run == exp_phase(1'b0), "R2", run, exp_phase(1'b0));
         chk(run >= TD && run <= ND, "R5", run, TD);
         chk(turbo_active == hist[2], "R7", turbo_active, hist[2]);
         run = 1;
      end else begin
         chk(turbo_active == prev_tb, "R4", turbo_active, prev_tb);
         run++;
      end
      prev_clk  = cpu_clk;
      prev_tb   = turbo_active;
      speed_sel = next_sel;
   endtask

   initial begin
      void'($urandom(32'h5eed_2048));
      repeat (3) @(negedge clk_ref);
      chk(cpu_clk == 1'b0, "R1", cpu_clk, 0);
      chk(turbo_active == 1'b0, "R1", turbo_active, 0);
      rst_n    = 1'b1;
      prev_clk = 1'b0;
      prev_tb  = 1'b0;
      hist     = 3'b000;
      run      = 1;
      // steady normal rate, first phase included (R2)
      for (int i = 0; i < 200; i++) step(1'b0);
      // steady turbo rate (R3)
      for (int i = 0; i < 200; i++) step(1'b1);
      for (int i = 0; i < 100; i++) step(1'b0);
      // flip every cycle: requests withdrawn before a toggle (R7, R5)
      for (int i = 0; i < 300; i++) step(~speed_sel);
      // flip every third cycle
      for (int i = 0; i < 400; i++) step((i % 3 == 0) ? ~speed_sel : speed_sel);
      // seeded random flips
      for (int i = 0; i < 3000; i++) step(($urandom % 6 == 0) ? ~speed_sel : speed_sel);
      // long random holds
      for (int i = 0; i < 40; i++) begin
         automatic logic s = $urandom % 2;
         automatic int   h = 1 + ($urandom % 25);
         for (int k = 0; k < h; k++) step(s);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end
endmodule